// File: doc/BRIEF.md
# Segmented Base-Bound Address Translator

This block maps a process's virtual addresses onto physical memory through a relocate-and-limit scheme. It keeps one base/limit register pair for each of three segments: instruction code, data and stack. The access kind that comes with each request selects the segment. The translator adds the segment's base to the virtual address. It also compares the virtual address against the segment's limit, so an access cannot reach outside its own region, and a stack or data access cannot reach the code.

Each request carries a virtual address, a 2-bit access kind and a valid strobe. The result is registered and appears one cycle after the request is accepted. The result is either a physical address or a fault with a cause code. A separate configuration port loads a segment's base and limit together. Only supervisor mode may use it. A user-mode attempt leaves the registers untouched and raises a privilege fault pulse.

Top module: `seg_xlate`

## Requirements
- R1: After reset `rsp_valid_o` and `priv_fault_o` are 0 and every limit is 0, so any access faults with cause 01 until a segment is programmed.
- R2: A request accepted with `req_valid_i` high gives `rsp_valid_o` high one cycle later. When it does not fault, `rsp_pa_o` = base + zero-extended virtual address, taken modulo 2^PA_W.
- R3: A virtual address greater than or equal to the selected segment's limit gives `rsp_fault_o`=1, `rsp_cause_o`=01 and `rsp_pa_o`=0.
- R4: Access kind 00 selects the code segment, 01 the data segment and 10 the stack segment. Writing one segment does not change the translation of the others.
- R5: Access kind 11 is reserved. It gives `rsp_fault_o`=1, `rsp_cause_o`=10 and `rsp_pa_o`=0.
- R6: A configuration write with `priv_i`=0 (user) changes no register and sets `priv_fault_o` high for one cycle, one cycle after the write. A write with `priv_i`=1 (supervisor) does not set it.
- R7: A supervisor write takes effect at its clock edge. A request accepted at that same edge still uses the old values, and later requests use the new ones.
- R8: Without a request, the next cycle shows `rsp_valid_o`=0, `rsp_fault_o`=0, `rsp_cause_o`=00 and `rsp_pa_o`=0.
- R9: A supervisor write with segment select 11 is ignored. All three segments keep their values and no privilege fault is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| priv_i | input | 1 | Current mode: 1 supervisor, 0 user |
| req_valid_i | input | 1 | Translation request strobe |
| req_kind_i | input | 2 | Access kind: 00 code, 01 data, 10 stack, 11 reserved |
| req_va_i | input | VA_W | Virtual address |
| cfg_we_i | input | 1 | Segment register write strobe |
| cfg_sel_i | input | 2 | Segment to write (same coding as access kind) |
| cfg_base_i | input | PA_W | New base |
| cfg_limit_i | input | VA_W | New limit (first unreachable virtual address) |
| rsp_valid_o | output | 1 | Response valid, one cycle after request |
| rsp_pa_o | output | PA_W | Physical address, 0 on fault |
| rsp_fault_o | output | 1 | Translation fault |
| rsp_cause_o | output | 2 | 00 none, 01 limit violation, 10 reserved kind |
| priv_fault_o | output | 1 | User-mode configuration attempt |

## Verification
The hardest case to reach is a configuration write and a translation landing on the same clock edge. Here the response has to use the register value from before the write. The bench drives both strobes in one cycle, then repeats the request alone and expects the new base. Address wrap-around is set up by giving the stack segment a base just below the top of the physical space. The limit edge is covered by requests at the limit minus one and at the limit itself.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int unsigned NUM_SEGS = 3;
  localparam int unsigned SEL_W    = 2;

  typedef enum logic [SEL_W-1:0] {
    KIND_CODE  = 2'b00,
    KIND_DATA  = 2'b01,
    KIND_STACK = 2'b10,
    KIND_RSVD  = 2'b11
  } seg_kind_e;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_LIMIT = 2'b01,
    CAUSE_KIND  = 2'b10
  } seg_cause_e;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_xlate_pkg::*;
#(
  parameter int unsigned VA_W = 16,
  parameter int unsigned PA_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             sup_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [PA_W-1:0]  wr_base_i,
  input  logic [VA_W-1:0]  wr_limit_i,
  input  logic [SEL_W-1:0] rd_sel_i,
  output logic [PA_W-1:0]  rd_base_o,
  output logic [VA_W-1:0]  rd_limit_o,
  output logic             rd_ok_o
);
  logic [PA_W-1:0] base_q  [NUM_SEGS];
  logic [VA_W-1:0] limit_q [NUM_SEGS];

  for (genvar g = 0; g < NUM_SEGS; g++) begin : g_seg
    logic hit;
    assign hit = wr_en_i && sup_i && (wr_sel_i == SEL_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[g]  <= '0;
        limit_q[g] <= '0;
      end else if (hit) begin
        base_q[g]  <= wr_base_i;
        limit_q[g] <= wr_limit_i;
      end
    end

    AST_USER_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && !sup_i) |=> ($stable(base_q[g]) && $stable(limit_q[g]))); // R6
    AST_RSVD_SEL_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_sel_i == KIND_RSVD) |=> ($stable(base_q[g]) && $stable(limit_q[g]))); // R9
  end

  always_comb begin
    rd_base_o  = '0;
    rd_limit_o = '0;
    rd_ok_o    = 1'b0;
    case (rd_sel_i)
      KIND_CODE:  begin rd_base_o = base_q[0]; rd_limit_o = limit_q[0]; rd_ok_o = 1'b1; end
      KIND_DATA:  begin rd_base_o = base_q[1]; rd_limit_o = limit_q[1]; rd_ok_o = 1'b1; end
      KIND_STACK: begin rd_base_o = base_q[2]; rd_limit_o = limit_q[2]; rd_ok_o = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int unsigned VA_W = 16,
  parameter int unsigned PA_W = 20
) (
  input  logic             kind_ok_i,
  input  logic [VA_W-1:0]  va_i,
  input  logic [PA_W-1:0]  base_i,
  input  logic [VA_W-1:0]  limit_i,
  output logic [PA_W-1:0]  pa_o,
  output logic             fault_o,
  output seg_cause_e       cause_o
);
  localparam int unsigned PAD_W = PA_W - VA_W;

  logic [PA_W-1:0] sum;
  assign sum = base_i + {{PAD_W{1'b0}}, va_i};

  always_comb begin
    pa_o    = '0;
    fault_o = 1'b1;
    cause_o = CAUSE_KIND;
    if (kind_ok_i) begin
      if (va_i >= limit_i) begin
        cause_o = CAUSE_LIMIT;
      end else begin
        fault_o = 1'b0;
        cause_o = CAUSE_NONE;
        pa_o    = sum;
      end
    end
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int unsigned VA_W = 16,
  parameter int unsigned PA_W = 20
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            priv_i,
  input  logic            req_valid_i,
  input  logic [1:0]      req_kind_i,
  input  logic [VA_W-1:0] req_va_i,
  input  logic            cfg_we_i,
  input  logic [1:0]      cfg_sel_i,
  input  logic [PA_W-1:0] cfg_base_i,
  input  logic [VA_W-1:0] cfg_limit_i,
  output logic            rsp_valid_o,
  output logic [PA_W-1:0] rsp_pa_o,
  output logic            rsp_fault_o,
  output logic [1:0]      rsp_cause_o,
  output logic            priv_fault_o
);
  logic [PA_W-1:0] sel_base;
  logic [VA_W-1:0] sel_limit;
  logic            sel_ok;
  logic [PA_W-1:0] chk_pa;
  logic            chk_fault;
  seg_cause_e      chk_cause;

  seg_regfile #(.VA_W(VA_W), .PA_W(PA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (cfg_we_i),
    .sup_i      (priv_i),
    .wr_sel_i   (cfg_sel_i),
    .wr_base_i  (cfg_base_i),
    .wr_limit_i (cfg_limit_i),
    .rd_sel_i   (req_kind_i),
    .rd_base_o  (sel_base),
    .rd_limit_o (sel_limit),
    .rd_ok_o    (sel_ok)
  );

  seg_check #(.VA_W(VA_W), .PA_W(PA_W)) u_check (
    .kind_ok_i (sel_ok),
    .va_i      (req_va_i),
    .base_i    (sel_base),
    .limit_i   (sel_limit),
    .pa_o      (chk_pa),
    .fault_o   (chk_fault),
    .cause_o   (chk_cause)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_pa_o     <= '0;
      rsp_fault_o  <= 1'b0;
      rsp_cause_o  <= CAUSE_NONE;
      priv_fault_o <= 1'b0;
    end else begin
      rsp_valid_o  <= req_valid_i;
      rsp_pa_o     <= req_valid_i ? chk_pa : '0;
      rsp_fault_o  <= req_valid_i && chk_fault;
      rsp_cause_o  <= req_valid_i ? chk_cause : CAUSE_NONE;
      priv_fault_o <= cfg_we_i && !priv_i;
    end
  end

  AST_RSP_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R2
  AST_FAULT_NO_PA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> (rsp_pa_o == '0 && rsp_cause_o != CAUSE_NONE)); // R3
  AST_RSVD_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_kind_i == KIND_RSVD) |=> (rsp_fault_o && rsp_cause_o == CAUSE_KIND)); // R5
  AST_USER_CFG_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !priv_i) |=> priv_fault_o); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (!rsp_fault_o && rsp_pa_o == '0 && rsp_cause_o == CAUSE_NONE)); // R8
endmodule

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;
  localparam int unsigned VA_W = 16;
  localparam int unsigned PA_W = 20;
  localparam int unsigned NV   = 10;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            priv_i = 1'b1;
  logic            req_valid_i = 1'b0;
  logic [1:0]      req_kind_i = 2'd0;
  logic [VA_W-1:0] req_va_i = '0;
  logic            cfg_we_i = 1'b0;
  logic [1:0]      cfg_sel_i = 2'd0;
  logic [PA_W-1:0] cfg_base_i = '0;
  logic [VA_W-1:0] cfg_limit_i = '0;
  logic            rsp_valid_o;
  logic [PA_W-1:0] rsp_pa_o;
  logic            rsp_fault_o;
  logic [1:0]      rsp_cause_o;
  logic            priv_fault_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk_i = ~clk_i;

  seg_xlate #(.VA_W(VA_W), .PA_W(PA_W)) u_seg_xlate (.*);

  // {kind, va, fault, cause, pa}
  localparam logic [40:0] VEC [NV] = '{
    {2'd0, 16'h0000, 1'b0, 2'd0, 20'h10000},
    {2'd0, 16'h00FF, 1'b0, 2'd0, 20'h100FF},
    {2'd0, 16'h0100, 1'b1, 2'd1, 20'h00000},
    {2'd1, 16'h07FF, 1'b0, 2'd0, 20'h207FF},
    {2'd1, 16'h0800, 1'b1, 2'd1, 20'h00000},
    {2'd1, 16'h0100, 1'b0, 2'd0, 20'h20100},
    {2'd2, 16'h0000, 1'b0, 2'd0, 20'hFFF00},
    {2'd2, 16'h01FF, 1'b0, 2'd0, 20'h000FF},
    {2'd2, 16'h0200, 1'b1, 2'd1, 20'h00000},
    {2'd3, 16'h0000, 1'b1, 2'd2, 20'h00000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, outputs of the posedge visible at the next negedge
  task automatic step(input logic we, input logic sup, input logic [1:0] sel,
                      input logic [PA_W-1:0] base, input logic [VA_W-1:0] lim,
                      input logic rv, input logic [1:0] kind, input logic [VA_W-1:0] va);
    @(negedge clk_i);
    priv_i = sup; cfg_we_i = we; cfg_sel_i = sel; cfg_base_i = base; cfg_limit_i = lim;
    req_valid_i = rv; req_kind_i = kind; req_va_i = va;
    @(negedge clk_i);
    cfg_we_i = 1'b0; req_valid_i = 1'b0; priv_i = 1'b1;
  endtask

  task automatic xlate(input logic [1:0] kind, input logic [VA_W-1:0] va);
    step(1'b0, 1'b1, 2'd0, '0, '0, 1'b1, kind, va);
  endtask

  task automatic cfg(input logic sup, input logic [1:0] sel,
                     input logic [PA_W-1:0] base, input logic [VA_W-1:0] lim);
    step(1'b1, sup, sel, base, lim, 1'b0, 2'd0, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 rsp_valid in reset", 32'(rsp_valid_o), 0);
    rst_ni = 1'b1;
    chk("R1 priv_fault after reset", 32'(priv_fault_o), 0);
    xlate(2'd1, 16'h0000);
    chk("R1 unprogrammed fault", 32'(rsp_fault_o), 1);
    chk("R1 unprogrammed cause", 32'(rsp_cause_o), 1);

    cfg(1'b1, 2'd0, 20'h10000, 16'h0100);
    chk("R6 no priv fault for supervisor", 32'(priv_fault_o), 0);
    cfg(1'b1, 2'd1, 20'h20000, 16'h0800);
    cfg(1'b1, 2'd2, 20'hFFF00, 16'h0200);

    for (int i = 0; i < NV; i++) begin
      xlate(VEC[i][40:39], VEC[i][38:23]);
      chk($sformatf("R2 valid vec %0d", i), 32'(rsp_valid_o), 1);
      chk($sformatf("R3/R4/R5 fault vec %0d", i), 32'(rsp_fault_o), 32'(VEC[i][22]));
      chk($sformatf("R3/R5 cause vec %0d", i), 32'(rsp_cause_o), 32'(VEC[i][21:20]));
      chk($sformatf("R2/R4 pa vec %0d", i), 32'(rsp_pa_o), 32'(VEC[i][19:0]));
    end

    // R8 idle cycle
    step(1'b0, 1'b1, 2'd0, '0, '0, 1'b0, 2'd0, 16'h0010);
    chk("R8 idle valid", 32'(rsp_valid_o), 0);
    chk("R8 idle pa", 32'(rsp_pa_o), 0);
    chk("R8 idle fault", 32'(rsp_fault_o), 0);

    // R6 user write ignored
    cfg(1'b0, 2'd0, 20'h00000, 16'hFFFF);
    chk("R6 priv fault pulse", 32'(priv_fault_o), 1);
    xlate(2'd0, 16'h0050);
    chk("R6 priv fault clears", 32'(priv_fault_o), 0);
    chk("R6 code base kept", 32'(rsp_pa_o), 32'h10050);
    xlate(2'd0, 16'h0100);
    chk("R6 code limit kept", 32'(rsp_fault_o), 1);

    // R9 reserved select
    cfg(1'b1, 2'd3, 20'h55555, 16'hFFFF);
    chk("R9 no priv fault", 32'(priv_fault_o), 0);
    xlate(2'd0, 16'h0010);
    chk("R9 code kept", 32'(rsp_pa_o), 32'h10010);
    xlate(2'd1, 16'h0010);
    chk("R9 data kept", 32'(rsp_pa_o), 32'h20010);
    xlate(2'd2, 16'h0010);
    chk("R9 stack kept", 32'(rsp_pa_o), 32'hFFF10);

    // R4 independence
    cfg(1'b1, 2'd1, 20'h30000, 16'h0800);
    xlate(2'd0, 16'h0020);
    chk("R4 code unaffected", 32'(rsp_pa_o), 32'h10020);
    xlate(2'd2, 16'h0020);
    chk("R4 stack unaffected", 32'(rsp_pa_o), 32'hFFF20);
    xlate(2'd1, 16'h0020);
    chk("R4 data rewritten", 32'(rsp_pa_o), 32'h30020);

    // R7 same-edge write and request
    step(1'b1, 1'b1, 2'd1, 20'h40000, 16'h0800, 1'b1, 2'd1, 16'h0001);
    chk("R7 same edge uses old base", 32'(rsp_pa_o), 32'h30001);
    xlate(2'd1, 16'h0001);
    chk("R7 next request uses new base", 32'(rsp_pa_o), 32'h40001);

    // R7/R3 shrink limit to zero
    step(1'b1, 1'b1, 2'd2, 20'hFFF00, 16'h0000, 1'b1, 2'd2, 16'h0000);
    chk("R7 old stack limit still open", 32'(rsp_fault_o), 0);
    xlate(2'd2, 16'h0000);
    chk("R3 zero limit faults", 32'(rsp_cause_o), 1);
    chk("R3 fault pa zero", 32'(rsp_pa_o), 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule